// File: doc/BRIEF.md
# Nested-Tile Surface Address Generator

This block turns a stream of pixel coordinates into byte addresses for a surface kept in memory as 4 KB tiles. Tiles sit across the surface in row-major order, each 128 bytes wide and 32 rows tall. Inside a tile the bytes are not stored row after row. They follow three nested levels, and column-major order applies at each level. Four 1 KB quadrants, two across and two down, are stored left column first. Each quadrant holds four 256-byte units in the same column-major 2x2 pattern. Each unit holds four 64-byte blocks, again 2x2 and column-major, and each block is four 16-byte rows.

A one-cycle `start` pulse captures the surface base address, the surface width in tiles and the pixel size. After that, each coordinate accepted on the input handshake gives one address on the output handshake, one register stage later. The block flags a coordinate that falls right of the surface edge and still produces its address. A full-rate stream moves one coordinate per clock.

Top module: `tile_addr_mapper`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1 while `start` is low.
- R2: In a cycle with `start` high, `cfg_base`, `cfg_pitch` and `cfg_bpp` are captured, and `in_ready` is 0. From the next cycle on, every coordinate uses the captured values, and later changes on the `cfg_*` inputs have no effect until the next `start`.
- R3: `cfg_bpp` codes 0, 1, 2, 3 and 4 select pixel sizes of 1, 2, 4, 8 and 16 bytes. Codes 5, 6 and 7 act as 16 bytes.
- R4: Let bx = x × pixel size. The address is base + ((y >> 5) × pitch + (bx >> 7)) × 4096 + offset, taken modulo 2^ADDR_W.
- R5: The 12-bit offset is built as follows. Bit 11 = bx[6], bit 10 = y[4], bit 9 = bx[5], bit 8 = y[3], bit 7 = bx[4], bit 6 = y[2], bits 5:4 = y[1:0], bits 3:0 = bx[3:0].
- R6: `out_oor` is 1 exactly when (bx >> 7) ≥ pitch. The address still follows R4.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr` and `out_oor` stay unchanged.
- R8: `in_ready` is 1 whenever `start` is low and either `out_valid` is 0 or `out_ready` is 1. An accepted coordinate shows on the output in the next cycle, so back-to-back coordinates flow at one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the configuration inputs |
| cfg_base | input | ADDR_W | Surface base byte address |
| cfg_pitch | input | PITCH_W | Surface width in tiles |
| cfg_bpp | input | 3 | Pixel size code (R3) |
| in_valid | input | 1 | Coordinate valid |
| in_ready | output | 1 | Coordinate accepted this cycle when valid |
| in_x | input | COORD_W | Pixel column |
| in_y | input | COORD_W | Pixel row |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Downstream takes the address |
| out_addr | output | ADDR_W | Byte address |
| out_oor | output | 1 | Coordinate lies right of the surface edge |

## Verification
A fault in the bit mapping shows up one cycle after acceptance as an address that differs in a single bit. Coordinates that step one field at a time, with base zero, expose each offset bit on its own. A stale or wrongly captured configuration register shows up on the first coordinate after `start` as a wrong tile multiple or a wrong pixel scale. The sweep over every `cfg_bpp` code reaches each shift path. A broken output register under backpressure changes `out_addr` while `out_ready` is low, or drops a coordinate. Both show up within two cycles when the held and the queued coordinates differ.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int TILE_LG     = 12;  // 4 KB tiles
  localparam int TILE_ROW_LG = 7;   // 128 bytes across a tile
  localparam int TILE_HT_LG  = 5;   // 32 rows down a tile
  localparam int MAX_SHIFT   = 4;   // 16-byte pixels

  // pixel size code to log2 of bytes; codes above 4 clamp to 16 bytes
  function automatic logic [2:0] bpp_shift(input logic [2:0] code);
    return (code > 3'(MAX_SHIFT)) ? 3'(MAX_SHIFT) : code;
  endfunction
endpackage

// File: rtl/tam_cfg.sv
module tam_cfg #(
  parameter int ADDR_W  = 32,
  parameter int PITCH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [PITCH_W-1:0] pitch_i,
  input  logic [2:0]         bpp_i,
  output logic [ADDR_W-1:0]  base_o,
  output logic [PITCH_W-1:0] pitch_o,
  output logic [2:0]         shift_o
);
  import tam_pkg::*;

  logic [ADDR_W-1:0]  base_d, base_q;
  logic [PITCH_W-1:0] pitch_d, pitch_q;
  logic [2:0]         shift_d, shift_q;

  always_comb begin
    base_d  = base_q;
    pitch_d = pitch_q;
    shift_d = shift_q;
    if (load) begin
      base_d  = base_i;
      pitch_d = pitch_i;
      shift_d = bpp_shift(bpp_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      pitch_q <= '0;
      shift_q <= '0;
    end else begin
      base_q  <= base_d;
      pitch_q <= pitch_d;
      shift_q <= shift_d;
    end
  end

  assign base_o  = base_q;
  assign pitch_o = pitch_q;
  assign shift_o = shift_q;
endmodule

// File: rtl/tam_tilepos.sv
module tam_tilepos #(
  parameter int COORD_W = 14,
  parameter int PITCH_W = 8
) (
  input  logic [COORD_W-1:0]  x,
  input  logic [COORD_W-1:0]  y,
  input  logic [2:0]          shift,
  input  logic [PITCH_W-1:0]  pitch,
  output logic [COORD_W-4:0]  tcol,
  output logic [COORD_W-6:0]  trow,
  output logic [6:0]          bx_lo,
  output logic [4:0]          y_lo,
  output logic                oor
);
  import tam_pkg::*;

  localparam int BX_W   = COORD_W + MAX_SHIFT;
  localparam int TCOL_W = BX_W - TILE_ROW_LG;
  localparam int CMP_W  = (TCOL_W > PITCH_W) ? TCOL_W : PITCH_W;

  logic [BX_W-1:0] bx;

  always_comb begin
    bx    = {{MAX_SHIFT{1'b0}}, x} << shift;
    tcol  = bx[BX_W-1:TILE_ROW_LG];
    bx_lo = bx[TILE_ROW_LG-1:0];
    trow  = y[COORD_W-1:TILE_HT_LG];
    y_lo  = y[TILE_HT_LG-1:0];
    oor   = CMP_W'(tcol) >= CMP_W'(pitch);
  end
endmodule

// File: rtl/tam_intra.sv
module tam_intra (
  input  logic [6:0]  bx_lo,
  input  logic [4:0]  y_lo,
  output logic [11:0] off
);
  // three 2x2 column-major levels: column bit above row bit at each level
  logic [2:0] col_bits;
  logic [2:0] row_bits;

  assign col_bits = bx_lo[6:4];
  assign row_bits = y_lo[4:2];

  genvar lv;
  generate
    for (lv = 0; lv < 3; lv++) begin : g_level
      assign off[7 + 2*lv] = col_bits[lv];
      assign off[6 + 2*lv] = row_bits[lv];
    end
  endgenerate

  assign off[5:4] = y_lo[1:0];
  assign off[3:0] = bx_lo[3:0];
endmodule

// File: rtl/tile_addr_mapper.sv
module tile_addr_mapper #(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 14,
  parameter int PITCH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [PITCH_W-1:0] cfg_pitch,
  input  logic [2:0]         cfg_bpp,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_addr,
  output logic               out_oor
);
  import tam_pkg::*;

  // reset: asserted asynchronously, released through two flops
  logic rst_m1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_m1 <= 1'b1;
      rst_sn <= rst_m1;
    end
  end

  logic [ADDR_W-1:0]  base_q;
  logic [PITCH_W-1:0] pitch_q;
  logic [2:0]         shift_q;

  tam_cfg #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W)) u_cfg (
    .clk(clk), .rst_n(rst_sn), .load(start),
    .base_i(cfg_base), .pitch_i(cfg_pitch), .bpp_i(cfg_bpp),
    .base_o(base_q), .pitch_o(pitch_q), .shift_o(shift_q)
  );

  logic [COORD_W-4:0] tcol;
  logic [COORD_W-6:0] trow;
  logic [6:0]         bx_lo;
  logic [4:0]         y_lo;
  logic               oor_c;

  tam_tilepos #(.COORD_W(COORD_W), .PITCH_W(PITCH_W)) u_pos (
    .x(in_x), .y(in_y), .shift(shift_q), .pitch(pitch_q),
    .tcol(tcol), .trow(trow), .bx_lo(bx_lo), .y_lo(y_lo), .oor(oor_c)
  );

  logic [11:0] off;
  tam_intra u_intra (.bx_lo(bx_lo), .y_lo(y_lo), .off(off));

  logic [ADDR_W-1:0] tile_idx, addr_c;
  always_comb begin
    tile_idx = ADDR_W'(trow) * ADDR_W'(pitch_q) + ADDR_W'(tcol);
    addr_c   = base_q + (tile_idx << TILE_LG) + ADDR_W'(off);
  end

  // output stage
  logic              vld_q, vld_d, oor_q, oor_d, load;
  logic [ADDR_W-1:0] addr_q, addr_d;

  assign in_ready = rst_sn && !start && (!vld_q || out_ready);
  assign load     = in_valid && in_ready;

  always_comb begin
    vld_d  = vld_q;
    addr_d = addr_q;
    oor_d  = oor_q;
    if (load) begin
      vld_d  = 1'b1;
      addr_d = addr_c;
      oor_d  = oor_c;
    end else if (out_ready) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      oor_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      oor_q  <= oor_d;
    end
  end

  assign out_valid = vld_q;
  assign out_addr  = addr_q;
  assign out_oor   = oor_q;
endmodule

// File: rtl/tam_chk.sv
module tam_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_oor
);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_oor));

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);

  p_start_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !in_ready);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_flow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start && (!out_valid || out_ready) |-> in_ready);
endmodule

bind tile_addr_mapper tam_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .start(start),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_oor(out_oor)
);

// File: tb/tile_addr_mapper_tb.sv
`timescale 1ns/1ps
module tile_addr_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n, start, in_valid, in_ready, out_valid, out_ready, out_oor;
  logic [31:0] cfg_base, out_addr;
  logic [7:0]  cfg_pitch;
  logic [2:0]  cfg_bpp;
  logic [13:0] in_x, in_y;

  int total = 0, bad = 0;
  bit done = 0;

  // model configuration (what the bench expects to be captured)
  logic [31:0] m_base;
  int          m_pitch, m_sel;

  always #2 clk = ~clk;

  tile_addr_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_pitch(cfg_pitch), .cfg_bpp(cfg_bpp), .in_valid(in_valid),
    .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_oor(out_oor)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int x, input int y);
    int lg, bx, tcol, trow;
    logic [11:0] off;
    lg   = (m_sel > 4) ? 4 : m_sel;
    bx   = x << lg;
    tcol = bx >> 7;
    trow = y >> 5;
    off  = {bx[6], y[4], bx[5], y[3], bx[4], y[2], y[1:0], bx[3:0]};
    return m_base + 32'((trow * m_pitch + tcol) << 12) + 32'(off);
  endfunction

  function automatic logic exp_oor(input int x);
    int lg;
    lg = (m_sel > 4) ? 4 : m_sel;
    return ((x << lg) >> 7) >= m_pitch;
  endfunction

  task automatic configure(input logic [31:0] b, input int p, input int s);
    @(negedge clk);
    start = 1'b1; cfg_base = b; cfg_pitch = 8'(p); cfg_bpp = 3'(s);
    #0.5;
    chk("R2 in_ready low during start", 32'(in_ready), 32'd0);
    @(negedge clk);
    start = 1'b0;
    m_base = b; m_pitch = p; m_sel = s;
  endtask

  task automatic send_check(input string req, input int x, input int y);
    @(negedge clk);
    in_valid = 1'b1; in_x = 14'(x); in_y = 14'(y); out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " addr"}, out_addr, exp_addr(x, y));
    chk({req, " oor"}, 32'(out_oor), 32'(exp_oor(x)));
  endtask

  task automatic t_reset;
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  // R5: base 0, one byte pixels, one field stepped at a time
  task automatic t_fields;
    logic [31:0] ex [9];
    int xs [9];
    int ys [9];
    xs = '{5, 16, 32, 64, 0, 0, 0, 0, 0};
    ys = '{0, 0, 0, 0, 1, 2, 4, 8, 16};
    ex = '{32'h5, 32'h80, 32'h200, 32'h800, 32'h10, 32'h20, 32'h40, 32'h100, 32'h400};
    configure(32'h0, 4, 0);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_x = 14'(xs[i]); in_y = 14'(ys[i]); out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R5 offset bit", out_addr, ex[i]);
    end
  endtask

  task automatic t_tiles;
    configure(32'h4000_0000, 3, 2);
    send_check("R4 tile col 1", 40, 3);
    send_check("R4 tile row 2", 10, 70);
    send_check("R4 mixed", 95, 33);
  endtask

  task automatic t_bpp;
    for (int s = 0; s < 8; s++) begin
      configure(32'h0010_0000, 16, s);
      send_check($sformatf("R3 bpp code %0d", s), 45, 9);
    end
  endtask

  task automatic t_oor;
    configure(32'h0, 2, 0);
    send_check("R6 last column inside", 255, 1);
    chk("R6 inside flag", 32'(out_oor), 32'd0);
    send_check("R6 first column outside", 256, 1);
    chk("R6 outside flag", 32'(out_oor), 32'd1);
  endtask

  task automatic t_latch;
    configure(32'h0001_0000, 4, 1);
    @(negedge clk);
    cfg_base = 32'hFFFF_0000; cfg_pitch = 8'd1; cfg_bpp = 3'd4;
    send_check("R2 inputs ignored after capture", 70, 40);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    configure(32'h2000, 5, 1);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_x = 14'd20; in_y = 14'd6;
    @(negedge clk);
    held = out_addr;
    chk("R7 first addr", held, exp_addr(20, 6));
    chk("R8 in_ready low when stalled", 32'(in_ready), 32'd0);
    in_x = 14'd100; in_y = 14'd50;
    repeat (3) @(negedge clk);
    chk("R7 addr held", out_addr, held);
    chk("R7 valid held", 32'(out_valid), 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 queued addr after release", out_addr, exp_addr(100, 50));
    @(negedge clk);
    chk("R7 drained", 32'(out_valid), 32'd0);
  endtask

  task automatic t_stream;
    configure(32'h0800_0000, 8, 2);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_x = 14'd0; in_y = 14'd0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk("R8 streaming valid", 32'(out_valid), 32'd1);
      chk("R8 streaming addr", out_addr, exp_addr(((i - 1) * 37) % 400, ((i - 1) * 13) % 100));
      chk("R8 streaming oor", 32'(out_oor), 32'(exp_oor(((i - 1) * 37) % 400)));
      if (i < 20) begin
        in_x = 14'((i * 37) % 400); in_y = 14'((i * 13) % 100);
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    cfg_base = '0; cfg_pitch = '0; cfg_bpp = '0; in_x = '0; in_y = '0;
    m_base = '0; m_pitch = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_fields();
    t_tiles();
    t_bpp();
    t_oor();
    t_latch();
    t_backpressure();
    t_stream();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule